// File: doc/BRIEF.md
# Cache Mode Control Register Block

This block holds the mode controls for an instruction cache and a data cache in one 32-bit control word. It also serves two fixed, read-only configuration words that describe each cache. Software reaches all three through a small word-addressed register port: select, write enable, byte offset, access size code, write data, and combinational read data. The current mode of each cache is driven out on its own port so the cache logic can follow it.

A one-cycle `irq_taken` pulse tells the block that the processor has just entered an interrupt. For each cache whose freeze-on-interrupt enable is set, an enabled cache moves to the frozen mode on that pulse. A disabled or already-frozen cache keeps its mode. Some control bits never hold state. Writing a one to either flush-command bit raises a one-cycle flush request for that cache, and the bit still reads back as zero.

Top module: `cache_mode_ctl`

## Requirements
- R1: After synchronous reset the control word reads 0x00000000, both mode outputs are 00, and neither flush request is high.
- R2: Control word bits [1:0] are the instruction cache mode and bits [3:2] are the data cache mode, with 00 = disabled, 01 = frozen, 11 = enabled. `imode` and `dmode` show these fields one cycle after the write.
- R3: When control bit 4 is set and `irq_taken` is high while the instruction mode is 11, the instruction mode becomes 01 on the next clock edge.
- R4: When control bit 5 is set and `irq_taken` is high while the data mode is 11, the data mode becomes 01 on the next clock edge.
- R5: On an `irq_taken` pulse, a mode that is 00 or 01 is left unchanged. A mode of 11 whose freeze enable is clear is also left unchanged.
- R6: A write to offset 0x00 stores the data with bits 14, 15, 16, 21 and 22 forced to zero, so those bits always read as zero. Every other bit, including bit 23, reads back as written.
- R7: Offset 0x04 reads 0x10220000 and offset 0x08 reads 0x18220000. Writes to either offset change nothing.
- R8: Only accesses with size code 2 (32-bit) are honoured. A write with any other code changes nothing, and a read with any other code returns zero. Size codes: 0 = byte, 1 = halfword, 2 = word, 3 = doubleword.
- R9: A read from any offset other than 0x00, 0x04 or 0x08 returns zero. A write to such an offset changes nothing.
- R10: A honoured write to offset 0x00 with bit 21 set raises `iflush_req` for exactly the one cycle after that edge. With bit 22 set, it raises `dflush_req` the same way.
- R11: If a honoured write to offset 0x00 and `irq_taken` occur in the same cycle, the freeze rule is applied to the newly written value, and the result is stored at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register access strobe |
| wr_en | input | 1 | 1 = write, 0 = read |
| offset | input | 8 | Byte offset of the register |
| size | input | 2 | Access size code (2 = 32-bit) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, zero when not a valid read |
| irq_taken | input | 1 | One-cycle interrupt-entry pulse |
| imode | output | 2 | Instruction cache mode |
| dmode | output | 2 | Data cache mode |
| iflush_req | output | 1 | One-cycle instruction cache flush request |
| dflush_req | output | 1 | One-cycle data cache flush request |

## Verification
The bench targets the freeze rule at its edges. It freezes each cache separately, so a design that mixed up the mode fields or the enable bits would freeze the wrong cache. It fires interrupts at disabled, unenabled and frozen caches, where a design that froze unconditionally would corrupt the mode. It raises a write and an interrupt in the same cycle, where a design that applied the freeze to the old value would leave the new mode enabled.

Other tests write all ones to confirm that the write-only bits read as zero while bit 23 is kept. They use sub-word sizes and stray offsets, which a loose decoder would let overwrite the control word. They also confirm that each flush pulse lasts exactly one cycle and belongs to the correct cache.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    typedef enum logic [1:0] {
        CM_OFF    = 2'b00,
        CM_FROZEN = 2'b01,
        CM_RSVD   = 2'b10,
        CM_ON     = 2'b11
    } cmode_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RS_CTRL,
        RS_ICFG,
        RS_DCFG,
        RS_NONE
    } reg_sel_e;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned NUM_CACHES = 2;
    localparam int unsigned FRZ_BASE   = 4;
    localparam int unsigned BIT_IFLUSH = 21;
    localparam int unsigned BIT_DFLUSH = 22;

    // bits that never hold state in the control word
    localparam logic [WORD_W-1:0] ZERO_MASK =
        (32'd1 << 14) | (32'd1 << 15) | (32'd1 << 16) |
        (32'd1 << BIT_IFLUSH) | (32'd1 << BIT_DFLUSH);

    function automatic cmode_e apply_freeze(cmode_e cur, logic en, logic evt);
        if (evt && en && cur == CM_ON) return CM_FROZEN;
        return cur;
    endfunction

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
    import ccr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned OFF_CTRL = 0,
    parameter int unsigned OFF_ICFG = 4,
    parameter int unsigned OFF_DCFG = 8
) (
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        size,
    output reg_sel_e          rsel,
    output logic              rd_en,
    output logic              ctrl_wr
);
    logic word_ok;

    always_comb begin
        word_ok = (size == SZ_WORD);
        if (offset == ADDR_W'(OFF_CTRL))      rsel = RS_CTRL;
        else if (offset == ADDR_W'(OFF_ICFG)) rsel = RS_ICFG;
        else if (offset == ADDR_W'(OFF_DCFG)) rsel = RS_DCFG;
        else                                  rsel = RS_NONE;
        rd_en   = sel && !wr_en && word_ok;
        ctrl_wr = sel && wr_en && word_ok && (rsel == RS_CTRL);
    end
endmodule

// File: rtl/ccr_ctrl_reg.sv
module ccr_ctrl_reg
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              irq_taken,
    output logic [WORD_W-1:0] ctrl_q,
    output logic              iflush_req,
    output logic              dflush_req
);
    logic [WORD_W-1:0] base_val;
    logic [WORD_W-1:0] next_val;

    always_comb begin
        base_val = ctrl_wr ? (wdata & ~ZERO_MASK) : ctrl_q;
    end

    // one freeze slice per cache: mode field at [2g+1:2g], enable at FRZ_BASE+g
    generate
        for (genvar g = 0; g < NUM_CACHES; g++) begin : g_frz
            always_comb begin
                next_val[2*g +: 2] = apply_freeze(cmode_e'(base_val[2*g +: 2]),
                                                  base_val[FRZ_BASE+g], irq_taken);
            end
        end
    endgenerate

    always_comb begin
        next_val[WORD_W-1:2*NUM_CACHES] = base_val[WORD_W-1:2*NUM_CACHES];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            iflush_req <= 1'b0;
            dflush_req <= 1'b0;
        end else begin
            ctrl_q     <= next_val;
            iflush_req <= ctrl_wr && wdata[BIT_IFLUSH];
            dflush_req <= ctrl_wr && wdata[BIT_DFLUSH];
        end
    end

    assert_ifreeze_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_taken && !ctrl_wr && ctrl_q[FRZ_BASE] && ctrl_q[1:0] == 2'b11)
        |=> ctrl_q[1:0] == 2'b01);

    assert_dfreeze_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_taken && !ctrl_wr && ctrl_q[FRZ_BASE+1] && ctrl_q[3:2] == 2'b11)
        |=> ctrl_q[3:2] == 2'b01);

    assert_keep_imode_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_taken && !ctrl_wr && ctrl_q[1:0] != 2'b11) |=> $stable(ctrl_q[1:0]));

    assert_zero_bits_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q & ZERO_MASK) == '0);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_wr && !irq_taken) |=> $stable(ctrl_q));

    assert_iflush_src_R10: assert property (@(posedge clk) disable iff (rst)
        iflush_req |-> $past(ctrl_wr && wdata[BIT_IFLUSH]));

    assert_dflush_src_R10: assert property (@(posedge clk) disable iff (rst)
        dflush_req |-> $past(ctrl_wr && wdata[BIT_DFLUSH]));
endmodule

// File: rtl/ccr_rdmux.sv
module ccr_rdmux
    import ccr_pkg::*;
#(
    parameter logic [WORD_W-1:0] ICFG_WORD = 32'h1022_0000,
    parameter logic [WORD_W-1:0] DCFG_WORD = 32'h1822_0000
) (
    input  logic              rd_en,
    input  reg_sel_e          rsel,
    input  logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (rsel)
                RS_CTRL: rdata = ctrl_q;
                RS_ICFG: rdata = ICFG_WORD;
                RS_DCFG: rdata = DCFG_WORD;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cache_mode_ctl.sv
module cache_mode_ctl
    import ccr_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       OFF_CTRL  = 0,
    parameter int unsigned       OFF_ICFG  = 4,
    parameter int unsigned       OFF_DCFG  = 8,
    parameter logic [WORD_W-1:0] ICFG_WORD = 32'h1022_0000,
    parameter logic [WORD_W-1:0] DCFG_WORD = 32'h1822_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        size,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              irq_taken,
    output logic [1:0]        imode,
    output logic [1:0]        dmode,
    output logic              iflush_req,
    output logic              dflush_req
);
    reg_sel_e          rsel;
    logic              rd_en;
    logic              ctrl_wr;
    logic [WORD_W-1:0] ctrl_q;

    ccr_decode #(
        .ADDR_W(ADDR_W), .OFF_CTRL(OFF_CTRL), .OFF_ICFG(OFF_ICFG), .OFF_DCFG(OFF_DCFG)
    ) u_dec (
        .sel(sel), .wr_en(wr_en), .offset(offset), .size(size),
        .rsel(rsel), .rd_en(rd_en), .ctrl_wr(ctrl_wr)
    );

    ccr_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .wdata(wdata), .irq_taken(irq_taken),
        .ctrl_q(ctrl_q), .iflush_req(iflush_req), .dflush_req(dflush_req)
    );

    ccr_rdmux #(.ICFG_WORD(ICFG_WORD), .DCFG_WORD(DCFG_WORD)) u_rd (
        .rd_en(rd_en), .rsel(rsel), .ctrl_q(ctrl_q), .rdata(rdata)
    );

    assign imode = ctrl_q[1:0];
    assign dmode = ctrl_q[3:2];

    assert_badsize_rd_R8: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr_en && size != SZ_WORD) |-> rdata == '0);

    assert_icfg_rd_R7: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr_en && size == SZ_WORD && offset == ADDR_W'(OFF_ICFG))
        |-> rdata == ICFG_WORD);

    assert_badoff_rd_R9: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr_en && offset != ADDR_W'(OFF_CTRL) && offset != ADDR_W'(OFF_ICFG)
         && offset != ADDR_W'(OFF_DCFG)) |-> rdata == '0);
endmodule

// File: tb/tb_cache_mode_ctl.sv
module tb_cache_mode_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  offset = '0;
    logic [1:0]  size = 2'd2;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_taken = 1'b0;
    logic [1:0]  imode, dmode;
    logic        iflush_req, dflush_req;

    int n_run = 0;
    int n_fail = 0;
    logic last_if, last_df;

    always #2.5 clk = ~clk;

    cache_mode_ctl dut (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .offset(offset), .size(size),
        .wdata(wdata), .rdata(rdata), .irq_taken(irq_taken), .imode(imode), .dmode(dmode),
        .iflush_req(iflush_req), .dflush_req(dflush_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] off, input logic [31:0] d,
                          input logic [1:0] sz = 2'd2, input logic irq = 1'b0);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; offset = off; wdata = d; size = sz; irq_taken = irq;
        @(negedge clk);
        last_if = iflush_req; last_df = dflush_req;
        sel = 1'b0; wr_en = 1'b0; irq_taken = 1'b0; size = 2'd2;
    endtask

    task automatic bus_rd(input logic [7:0] off, output logic [31:0] d,
                          input logic [1:0] sz = 2'd2);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; offset = off; size = sz;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0; size = 2'd2;
    endtask

    task automatic pulse_irq();
        @(negedge clk);
        irq_taken = 1'b1;
        @(negedge clk);
        irq_taken = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_rd(8'h00, v);
        chk("R1 ctrl after reset", v, 32'h0);
        chk("R1 modes after reset", {28'h0, dmode, imode}, 32'h0);
        chk("R1 flush idle", {30'h0, iflush_req, dflush_req}, 32'h0);
    endtask

    task automatic t_modes();
        logic [31:0] v;
        bus_wr(8'h00, 32'h0000_0007);
        chk("R2 imode output", {30'h0, imode}, 32'h3);
        chk("R2 dmode output", {30'h0, dmode}, 32'h1);
        bus_rd(8'h00, v);
        chk("R2 ctrl readback", v, 32'h7);
    endtask

    task automatic t_ifreeze();
        logic [31:0] v;
        bus_wr(8'h00, 32'h0000_001F);
        pulse_irq();
        chk("R3 imode frozen", {30'h0, imode}, 32'h1);
        chk("R5 dmode w/o enable kept", {30'h0, dmode}, 32'h3);
        bus_rd(8'h00, v);
        chk("R3 ctrl after freeze", v, 32'h1D);
        pulse_irq();
        chk("R5 frozen stays frozen", {30'h0, imode}, 32'h1);
    endtask

    task automatic t_dfreeze();
        logic [31:0] v;
        bus_wr(8'h00, 32'h0000_002C);
        pulse_irq();
        chk("R4 dmode frozen", {30'h0, dmode}, 32'h1);
        bus_rd(8'h00, v);
        chk("R4 ctrl after freeze", v, 32'h24);
        bus_wr(8'h00, 32'h0000_0030);
        pulse_irq();
        bus_rd(8'h00, v);
        chk("R5 disabled unchanged", v, 32'h30);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        bus_wr(8'h00, 32'hFFFF_FFFF);
        bus_rd(8'h00, v);
        chk("R6 write-only bits zero", v, 32'hFF9E_3FFF);
        bus_wr(8'h00, 32'h0080_0000);
        bus_rd(8'h00, v);
        chk("R6 bit23 kept", v, 32'h0080_0000);
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        bus_rd(8'h04, v);
        chk("R7 icfg word", v, 32'h1022_0000);
        bus_rd(8'h08, v);
        chk("R7 dcfg word", v, 32'h1822_0000);
        bus_wr(8'h04, 32'h0000_0003);
        bus_wr(8'h08, 32'h0000_000C);
        bus_rd(8'h04, v);
        chk("R7 icfg after write", v, 32'h1022_0000);
        bus_rd(8'h00, v);
        chk("R7 ctrl untouched by cfg write", v, 32'h0080_0000);
    endtask

    task automatic t_size();
        logic [31:0] v;
        bus_wr(8'h00, 32'h0000_0003, 2'd0);
        bus_wr(8'h00, 32'h0000_0003, 2'd1);
        bus_wr(8'h00, 32'h0000_0003, 2'd3);
        bus_rd(8'h00, v);
        chk("R8 sub-word writes ignored", v, 32'h0080_0000);
        bus_rd(8'h04, v, 2'd1);
        chk("R8 halfword read zero", v, 32'h0);
        bus_rd(8'h00, v, 2'd0);
        chk("R8 byte read zero", v, 32'h0);
    endtask

    task automatic t_badoff();
        logic [31:0] v;
        bus_rd(8'h0C, v);
        chk("R9 unknown read zero", v, 32'h0);
        bus_wr(8'h0C, 32'h0000_000F);
        bus_wr(8'h40, 32'h0000_000F);
        bus_wr(8'h01, 32'h0000_000F);
        bus_rd(8'h00, v);
        chk("R9 unknown write no effect", v, 32'h0080_0000);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        bus_wr(8'h00, 32'h0020_0000);
        chk("R10 iflush pulse", {30'h0, last_if, last_df}, 32'h2);
        #1;
        @(negedge clk);
        chk("R10 iflush one cycle", {31'h0, iflush_req}, 32'h0);
        bus_wr(8'h00, 32'h0040_0000);
        chk("R10 dflush pulse", {30'h0, last_if, last_df}, 32'h1);
        @(negedge clk);
        chk("R10 dflush one cycle", {31'h0, dflush_req}, 32'h0);
        bus_rd(8'h00, v);
        chk("R10 flush bits not stored", v, 32'h0);
        bus_wr(8'h00, 32'h0060_0000, 2'd0);
        chk("R10 no pulse on byte write", {30'h0, last_if, last_df}, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        bus_wr(8'h00, 32'h0000_003F, 2'd2, 1'b1);
        bus_rd(8'h00, v);
        chk("R11 write+irq both frozen", v, 32'h35);
        bus_wr(8'h00, 32'h0000_001B, 2'd2, 1'b1);
        bus_rd(8'h00, v);
        chk("R11 write+irq imode frozen", v, 32'h19);
    endtask

    initial begin
        #200000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_modes();
        t_ifreeze();
        t_dfreeze();
        t_mask();
        t_cfg();
        t_size();
        t_badoff();
        t_flush();
        t_same_cycle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule